// File: doc/BRIEF.md
# Configurable SPI Master Engine

This block is a full-duplex serial master. Each accepted word is shifted out on the serial data output while a word of the same length is shifted in from the serial data input, using a serial clock derived from the system clock. Clock polarity, clock phase, word length (8 or 16 bits), bit order and the clock divider are all supplied as run-time inputs. They are captured when a word is accepted and held for that whole word.

The user side is a simple pair of registers. A write strobe loads the transmit word and starts a frame when the engine is idle. The `tx_empty` flag shows that the engine can take a new word. At the end of the frame the received word lands in a holding register, and `rx_ready` rises. A read strobe clears `rx_ready`. The active-low select line is a registered copy of a user bit and is never touched by the shift engine. Software therefore brackets multi-word transactions itself.

Top module: `spi_master_engine`

## Requirements
- R1: Reset leaves `sck`=0, `mosi`=0, `cs_n`=1, `tx_empty`=1, `rx_ready`=0 and `rx_data`=0.
- R2: While idle, `sck` follows `cfg_cpol` one cycle later. A frame of N bits makes exactly 2N `sck` toggles. Each toggle comes 2^n system clocks after the previous one, or after the accepting edge for the first toggle, where n is the 3-bit `cfg_div` code, so the divide ratio is 2^(n+1) and ranges from 2 to 256.
- R3: With phase 0 (`cfg_cpha`=0) `miso` is captured on toggles 1, 3, 5 and so on. With phase 1 it is captured on toggles 2, 4, 6 and so on. The k-th capture fills bit k of the transfer order.
- R4: With phase 0 the first transmit bit appears on `mosi` at the accepting edge, and later bits change on the even toggles. With phase 1 `mosi` keeps its old value until toggle 1, and bits change on the odd toggles.
- R5: `cfg_wide`=0 selects 8-bit frames that use `tx_data[7:0]` and return `rx_data[15:8]`=0. `cfg_wide`=1 selects 16-bit frames.
- R6: `cfg_lsb_first`=0 sends and receives the most significant bit first. `cfg_lsb_first`=1 sends and receives bit 0 first.
- R7: `tx_wr` while `tx_empty`=1 starts a frame, and `tx_empty` falls at that edge. `tx_empty` rises at the edge of the final toggle. `tx_wr` while `tx_empty`=0 is ignored.
- R8: `rx_ready` and `rx_data` update at the edge of the final toggle. `rx_rd` clears `rx_ready`, except that a completion in the same cycle wins.
- R9: Changes to any configuration input while a frame is in progress have no effect on that frame.
- R10: `cs_n` equals the inverse of `cs_sel` one cycle later, whatever the engine is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_cpha | input | 1 | Capture on odd (0) or even (1) toggles |
| cfg_wide | input | 1 | 0: 8-bit frame, 1: 16-bit frame |
| cfg_lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| cfg_div | input | 3 | Divider code n, ratio 2^(n+1) |
| cs_sel | input | 1 | User select bit, 1 asserts the select line |
| tx_wr | input | 1 | Transmit word write strobe |
| tx_data | input | 16 | Transmit word |
| tx_empty | output | 1 | Engine idle, ready for a word |
| rx_rd | input | 1 | Receive word read strobe |
| rx_data | output | 16 | Last received word |
| rx_ready | output | 1 | Received word not yet read |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low select |
| miso | input | 1 | Serial data in |

## Verification
If the bit index or the toggle count is off, the design shows a wrong `mosi` value or an extra or missing `sck` toggle within one half-period of the point where it goes wrong. A wrong divider state shows as a toggle that comes early or late by at least one system clock. A bad capture position only appears when `rx_data` is loaded at the end of the frame. The loopback frames expose it there, as a word that differs from the transmitted one.

// File: rtl/spim_pkg.sv
package spim_pkg;

   parameter int unsigned SPIM_DIV_W = 3;

   typedef enum logic {
      ORDER_MSB = 1'b0,
      ORDER_LSB = 1'b1
   } spim_order_e;

   typedef struct packed {
      logic        cpha;
      logic        wide;
      spim_order_e order;
   } spim_fmt_t;

endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
   parameter int unsigned DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] code,
   output logic             tick
);
   localparam int unsigned CNT_W = 1 << DIV_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   // half period of sck is 2^code system clocks
   assign limit = (CNT_W'(1) << code) - CNT_W'(1);
   assign tick  = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
   import spim_pkg::*;
#(
   parameter int unsigned WIDE_W   = 16,
   parameter int unsigned NARROW_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WIDE_W-1:0] tx_word,
   input  spim_fmt_t         fmt_in,
   input  logic              tick,
   input  logic              miso,
   output logic              mosi,
   output logic              done,
   output logic [WIDE_W-1:0] rx_word
);
   localparam int unsigned EC_W = $clog2(2 * WIDE_W + 1);
   localparam int unsigned KW   = $clog2(WIDE_W);

   spim_fmt_t         fmt_q;
   logic [WIDE_W-1:0] tx_q;
   logic [WIDE_W-1:0] rx_q;
   logic [WIDE_W-1:0] rx_next;
   logic [EC_W-1:0]   ecnt_q;
   logic              mosi_q;

   logic [EC_W-1:0]   edge_n;
   logic [EC_W-1:0]   nbits;
   logic [EC_W-1:0]   nbits_in;
   logic [EC_W-1:0]   samp_k;
   logic [EC_W-1:0]   drive_k;
   logic [EC_W-1:0]   samp_pos;
   logic [EC_W-1:0]   drive_pos;
   logic [EC_W-1:0]   first_pos;
   logic              is_samp;
   logic              drive_ok;

   function automatic logic [EC_W-1:0] bit_pos(input logic [EC_W-1:0] k,
                                               input logic            lsb,
                                               input logic [EC_W-1:0] n);
      return lsb ? k : (n - EC_W'(1) - k);
   endfunction

   assign edge_n    = ecnt_q + EC_W'(1);
   assign nbits     = fmt_q.wide ? EC_W'(WIDE_W) : EC_W'(NARROW_W);
   assign nbits_in  = fmt_in.wide ? EC_W'(WIDE_W) : EC_W'(NARROW_W);
   assign is_samp   = edge_n[0] != fmt_q.cpha;
   assign samp_k    = (edge_n - EC_W'(1) - EC_W'(fmt_q.cpha)) >> 1;
   assign drive_k   = (edge_n - EC_W'(fmt_q.cpha)) >> 1;
   assign drive_ok  = drive_k < nbits;
   assign samp_pos  = bit_pos(samp_k, fmt_q.order == ORDER_LSB, nbits);
   assign drive_pos = bit_pos(drive_k, fmt_q.order == ORDER_LSB, nbits);
   assign first_pos = bit_pos('0, fmt_in.order == ORDER_LSB, nbits_in);
   assign done      = tick && (edge_n == (nbits << 1));

   // per-bit capture lanes
   for (genvar i = 0; i < WIDE_W; i++) begin : g_cap
      assign rx_next[i] = (tick && is_samp && samp_pos == EC_W'(i)) ? miso : rx_q[i];
   end

   assign rx_word = rx_next;
   assign mosi    = mosi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q  <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
         ecnt_q <= '0;
         mosi_q <= 1'b0;
      end else if (load) begin
         fmt_q  <= fmt_in;
         tx_q   <= tx_word;
         rx_q   <= '0;
         ecnt_q <= '0;
         if (!fmt_in.cpha)
            mosi_q <= tx_word[first_pos[KW-1:0]];
      end else if (tick) begin
         ecnt_q <= edge_n;
         rx_q   <= rx_next;
         if (!is_samp && drive_ok)
            mosi_q <= tx_q[drive_pos[KW-1:0]];
      end
   end
endmodule

// File: rtl/spim_rxhold.sv
module spim_rxhold #(
   parameter int unsigned WIDE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [WIDE_W-1:0] word_in,
   input  logic              rd,
   output logic [WIDE_W-1:0] data_out,
   output logic              ready
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_out <= '0;
         ready    <= 1'b0;
      end else if (done) begin
         data_out <= word_in;
         ready    <= 1'b1;
      end else if (rd) begin
         ready    <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
   import spim_pkg::*;
#(
   parameter int unsigned WIDE_W   = 16,
   parameter int unsigned NARROW_W = 8,
   parameter int unsigned DIV_W    = SPIM_DIV_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              cfg_wide,
   input  logic              cfg_lsb_first,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              cs_sel,
   input  logic              tx_wr,
   input  logic [WIDE_W-1:0] tx_data,
   output logic              tx_empty,
   input  logic              rx_rd,
   output logic [WIDE_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              sck,
   output logic              mosi,
   output logic              cs_n,
   input  logic              miso
);
   if (NARROW_W == 0 || NARROW_W >= WIDE_W) begin : g_bad_width
      $error("NARROW_W must be nonzero and below WIDE_W");
   end
   if (DIV_W == 0 || DIV_W > 5) begin : g_bad_div
      $error("DIV_W must lie in 1..5");
   end

   logic             busy_q;
   logic             sck_q;
   logic             csn_q;
   logic [DIV_W-1:0] div_q;
   logic             load;
   logic             tick;
   logic             done;
   logic [WIDE_W-1:0] rx_word;
   spim_fmt_t        fmt_in;

   assign load   = tx_wr && !busy_q;
   assign fmt_in = '{cpha: cfg_cpha, wide: cfg_wide,
                     order: cfg_lsb_first ? ORDER_LSB : ORDER_MSB};

   spim_baud #(.DIV_W(DIV_W)) u_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy_q),
      .code (div_q),
      .tick (tick)
   );

   spim_shift #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .tx_word(tx_data),
      .fmt_in (fmt_in),
      .tick   (tick),
      .miso   (miso),
      .mosi   (mosi),
      .done   (done),
      .rx_word(rx_word)
   );

   spim_rxhold #(.WIDE_W(WIDE_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .done    (done),
      .word_in (rx_word),
      .rd      (rx_rd),
      .data_out(rx_data),
      .ready   (rx_ready)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
         csn_q  <= 1'b1;
         div_q  <= '0;
      end else begin
         csn_q <= !cs_sel;
         if (load) begin
            busy_q <= 1'b1;
            div_q  <= cfg_div;
         end else if (done) begin
            busy_q <= 1'b0;
         end
         if (!busy_q)
            sck_q <= cfg_cpol;
         else if (tick)
            sck_q <= !sck_q;
      end
   end

   assign tx_empty = !busy_q;
   assign sck      = sck_q;
   assign cs_n     = csn_q;
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
   parameter int unsigned WIDE_W   = 16,
   parameter int unsigned NARROW_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic cfg_cpol,
   input logic cs_sel,
   input logic tx_wr,
   input logic tx_empty,
   input logic rx_rd,
   input logic rx_ready,
   input logic sck,
   input logic cs_n
);
   logic       armed;
   logic       sck_q;
   logic [7:0] tog_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         sck_q   <= 1'b0;
         tog_cnt <= '0;
      end else begin
         armed <= 1'b1;
         sck_q <= sck;
         if (tx_empty)
            tog_cnt <= '0;
         else if (sck != sck_q)
            tog_cnt <= tog_cnt + 8'd1;
      end
   end

   // R10
   cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> cs_n == !$past(cs_sel));

   // R2
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && tx_empty && $past(tx_empty) |-> sck == $past(cfg_cpol));

   // R2
   toggle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $rose(tx_empty) |->
         (tog_cnt + 8'(sck != sck_q)) == 8'(2 * NARROW_W) ||
         (tog_cnt + 8'(sck != sck_q)) == 8'(2 * WIDE_W));

   // R7
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && tx_empty && tx_wr |=> !tx_empty);

   // R8
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty && rx_rd |=> !rx_ready);
endmodule

bind spi_master_engine spim_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cfg_cpol(cfg_cpol),
   .cs_sel  (cs_sel),
   .tx_wr   (tx_wr),
   .tx_empty(tx_empty),
   .rx_rd   (rx_rd),
   .rx_ready(rx_ready),
   .sck     (sck),
   .cs_n    (cs_n)
);

// File: tb/spi_master_engine_test.sv
module spi_master_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_wide = 1'b0, cfg_lsb_first = 1'b0;
   logic [2:0]  cfg_div = 3'd0;
   logic        cs_sel = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0, miso = 1'b0;
   logic [15:0] tx_data = 16'h0;
   logic        tx_empty, rx_ready, sck, mosi, cs_n;
   logic [15:0] rx_data;

   spi_master_engine uut (
      .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_wide(cfg_wide), .cfg_lsb_first(cfg_lsb_first), .cfg_div(cfg_div),
      .cs_sel(cs_sel), .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty),
      .rx_rd(rx_rd), .rx_data(rx_data), .rx_ready(rx_ready), .sck(sck),
      .mosi(mosi), .cs_n(cs_n), .miso(miso)
   );

   always #5 clk = ~clk;

   int  compared = 0, mismatched = 0, cyc = 0;
   bit  loopback = 1'b0, done_flag = 1'b0;
   int  rd_pct = 0;

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   // behavioural reference
   bit          m_busy = 0, m_sck = 0, m_mosi = 0, m_csn = 1, m_rxf = 0;
   bit          m_cpha = 0, m_lsb = 0;
   logic [15:0] m_rxd = 0, m_acc = 0;
   int          m_div = 0, m_e = 0, m_h = 1, m_n = 8, m_ns = 0;
   bit          q_tx[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_sck = 0; m_mosi = 0; m_csn = 1; m_rxf = 0; m_rxd = 0;
      end else begin
         m_csn = !cs_sel;
         if (rx_rd) m_rxf = 0;
         if (!m_busy) begin
            m_sck = cfg_cpol;
            if (tx_wr) begin
               m_busy = 1;
               m_n = cfg_wide ? 16 : 8;
               m_h = 1 << cfg_div;
               m_cpha = cfg_cpha;
               m_lsb = cfg_lsb_first;
               q_tx.delete();
               for (int i = 0; i < m_n; i++)
                  q_tx.push_back(tx_data[m_lsb ? i : m_n - 1 - i]);
               m_acc = 0; m_ns = 0; m_div = 0; m_e = 0;
               if (!m_cpha) m_mosi = q_tx.pop_front();
            end
         end else begin
            m_div++;
            if (m_div == m_h) begin
               m_div = 0;
               m_e++;
               m_sck = !m_sck;
               if (((m_e % 2) == 1) == !m_cpha) begin
                  m_acc[m_lsb ? m_ns : m_n - 1 - m_ns] = miso;
                  m_ns++;
               end else if (q_tx.size() > 0) begin
                  m_mosi = q_tx.pop_front();
               end
               if (m_e == 2 * m_n) begin
                  m_busy = 0;
                  m_rxd = m_acc;
                  m_rxf = 1;
               end
            end
         end
      end
   end

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         check("R2", "sck", 32'(sck), 32'(m_sck));
         check("R4", "mosi", 32'(mosi), 32'(m_mosi));
         check("R10", "cs_n", 32'(cs_n), 32'(m_csn));
         check("R7", "tx_empty", 32'(tx_empty), 32'(!m_busy));
         check("R8", "rx_ready", 32'(rx_ready), 32'(m_rxf));
         check("R3", "rx_data", 32'(rx_data), 32'(m_rxd));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done_flag) begin
         done_flag = 1;
         mismatched++;
         $display("FAIL R7 watchdog actual=%0d expected<190000", cyc);
         finish_run();
      end
   end

   task automatic step();
      @(negedge clk);
      miso = loopback ? mosi : 1'($urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0) cs_sel = !cs_sel;
      rx_rd = (rd_pct > 0) && ($urandom_range(0, 99) < rd_pct);
   endtask

   task automatic frame(input bit cp, input bit ph, input bit wd, input bit lf,
                        input logic [2:0] dv, input logic [15:0] word, input bit disturb);
      logic [15:0] expw;
      step();
      cfg_cpol = cp; cfg_cpha = ph; cfg_wide = wd; cfg_lsb_first = lf; cfg_div = dv;
      step();
      tx_wr = 1; tx_data = word;
      step();
      tx_wr = 0;
      if (disturb) begin
         step(); step();
         tx_wr = 1; tx_data = ~word;
         cfg_cpha = !ph; cfg_wide = !wd; cfg_lsb_first = !lf; cfg_div = dv + 3'd1;
         cfg_cpol = !cp;
         step();
         tx_wr = 0;
      end
      while (!tx_empty) step();
      expw = wd ? word : {8'h00, word[7:0]};
      if (loopback) begin
         if (disturb) check("R9", "loopback word under cfg change", 32'(rx_data), 32'(expw));
         else if (lf) check("R6", "loopback lsb-first", 32'(rx_data), 32'(expw));
         else check("R5", "loopback msb-first", 32'(rx_data), 32'(expw));
      end
      step(); step();
      if (disturb) check("R7", "write while busy ignored", 32'(tx_empty), 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "sck", 32'(sck), 32'd0);
      check("R1", "mosi", 32'(mosi), 32'd0);
      check("R1", "cs_n", 32'(cs_n), 32'd1);
      check("R1", "tx_empty", 32'(tx_empty), 32'd1);
      check("R1", "rx_ready", 32'(rx_ready), 32'd0);
      check("R1", "rx_data", 32'(rx_data), 32'd0);
      rst_n = 1;

      loopback = 1;
      for (int m = 0; m < 16; m++)
         for (int d = 0; d < 2; d++)
            frame(m[0], m[1], m[2], m[3], 3'(d), 16'($urandom), 1'b0);

      loopback = 0; rd_pct = 10;
      for (int m = 0; m < 16; m++)
         frame(m[0], m[1], m[2], m[3], 3'd2, 16'($urandom), 1'b0);

      rd_pct = 0;
      for (int d = 0; d < 8; d++)
         frame(d[0], d[1], 1'b0, d[2], 3'(d), 16'($urandom), 1'b0);

      loopback = 1;
      for (int m = 0; m < 4; m++)
         frame(m[0], m[1], 1'b0, m[1], 3'd0, 16'($urandom), 1'b1);

      // R8 read clears the flag
      frame(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 16'hA5C3, 1'b0);
      check("R8", "ready after frame", 32'(rx_ready), 32'd1);
      @(negedge clk); rx_rd = 1;
      @(negedge clk); rx_rd = 0;
      check("R8", "ready after read", 32'(rx_ready), 32'd0);
      check("R8", "data kept after read", 32'(rx_data), 32'hA5C3);

      repeat (4) @(negedge clk);
      done_flag = 1;
      finish_run();
   end
endmodule